// File: doc/BRIEF.md
# Tail-Pointer Descriptor Ring Fetcher

This block is the front end of one DMA channel. It walks a ring of fixed-size descriptors in memory. Each descriptor is four 32-bit words, sixteen bytes, placed one after another from a programmed base address. Software programs the base and the number of descriptors in the ring, then sets a start bit. After that, software hands descriptors to the engine only by moving a tail pointer. The tail holds the address one past the last descriptor that is ready, so the engine owns every descriptor from its current pointer up to the one before the tail.

For each descriptor it owns, the engine makes four word reads in a row over a request/grant/response memory port. It then presents the whole descriptor to a downstream consumer as a single 128-bit beat on a valid/ready handshake. When the consumer takes the beat, the current pointer moves one descriptor forward and wraps to the base after the last slot.

When the current pointer reaches the tail, the engine suspends and gives a one-cycle pulse. It stays suspended until software writes a tail value that differs from the current pointer. Software can read the current pointer and a status word at any time through the register port.

Top module: `ring_desc_fetch`

## Requirements
- R1: After reset, `mem_req`, `desc_valid`, `suspended` and `suspend_pulse` are low, and a register read returns 0 for both the status word (offset 5) and the current pointer (offset 4).
- R2: Writing 1 to bit 0 of the control register (offset 0) while the engine is idle or suspended does two things. It loads the current pointer with the base, and it starts operation. If the tail equals the base at that point, the engine suspends without reading memory.
- R3: A descriptor at address A is read as four single-word requests at A, A+4, A+8 and A+12, in that order. The word from A+4k appears on `desc_data[32k+31:32k]`, and `desc_addr` equals A.
- R4: `mem_req` stays high with a stable `mem_addr` until `mem_gnt` is seen. Only one read is outstanding at a time, and the next request follows the response on `mem_rvalid`.
- R5: `desc_valid` stays high with stable `desc_data` and `desc_addr` until `desc_ready` is high. The current pointer advances by 16 bytes on the cycle of that handshake.
- R6: Descriptors are delivered in ring order from the current pointer up to the one before the tail. When the current pointer equals the tail, the engine suspends. `suspended` (also status bit 0) goes high, and `suspend_pulse` is high for exactly the first cycle of suspension.
- R7: After the descriptor at ring slot count-1 is taken, the next descriptor fetched is the one at the base address.
- R8: While suspended, a tail write (offset 3) whose value differs from the current pointer resumes fetching. A tail write equal to the current pointer leaves the engine suspended, with no pulse and no memory request.
- R9: While the engine is busy (status bit 1), writes to the base (offset 1), the ring count (offset 2) and the start bit are ignored. Their readback and the order of delivered descriptors are unchanged.
- R10: Reading offset 4 at any time returns base + 16 × slot, where slot is the ring slot of the next descriptor to be delivered.
- R11: The low four bits of base and tail writes are dropped and read back as zero.
- R12: While suspended, `mem_req` and `desc_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read offset |
| reg_rdata | output | 32 | Register read data, combinational from `reg_raddr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after the grant |
| mem_rdata | input | 32 | Read data word |
| desc_valid | output | 1 | Descriptor beat valid |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_data | output | 128 | Descriptor, word 0 in the low bits |
| desc_addr | output | ADDR_W | Address of the presented descriptor |
| suspended | output | 1 | Engine is suspended at the tail |
| suspend_pulse | output | 1 | One-cycle pulse on entry to suspension |

## Verification
The bench builds the block with a 16-bit address and a 3-bit ring count. Every ring size from 1 to 7 slots can therefore be swept in one run. For each size the bench moves the tail by every step from one slot to a full lap less one. This reaches every wrap position and every count of descriptors per burst. Irregular grant, response-delay and ready patterns exercise the holding rules on both ports. Writes made while a run is in progress test the lockout of base, count and start.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int DESC_W     = WORD_W * DESC_WORDS;
  localparam int DESC_SHIFT = 4;
  localparam int WCNT_W     = 2;
  localparam int REG_AW     = 3;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_BASE  = 3'd1;
  localparam logic [REG_AW-1:0] RA_COUNT = 3'd2;
  localparam logic [REG_AW-1:0] RA_TAIL  = 3'd3;
  localparam logic [REG_AW-1:0] RA_CUR   = 3'd4;
  localparam logic [REG_AW-1:0] RA_STAT  = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_REQ,
    ST_WAIT,
    ST_HOLD,
    ST_SUSP
  } fetch_st_e;
endpackage

// File: rtl/rdf_rst_sync.sv
module rdf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rdf_regs.sv
module rdf_regs
  import rdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              suspended,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] base_q,
  output logic [LEN_W-1:0]  count_q,
  output logic [ADDR_W-1:0] tail_eff,
  output logic              tail_wr,
  output logic              start_req
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << DESC_SHIFT) - 1);

  logic [ADDR_W-1:0] tail_q;
  logic [ADDR_W-1:0] wr_addr_val;
  logic              base_en;
  logic              count_en;

  assign wr_addr_val = reg_wdata[ADDR_W-1:0] & ALIGN_MASK;
  assign base_en     = reg_wr && (reg_waddr == RA_BASE)  && !busy;
  assign count_en    = reg_wr && (reg_waddr == RA_COUNT) && !busy;
  assign tail_wr     = reg_wr && (reg_waddr == RA_TAIL);
  assign start_req   = reg_wr && (reg_waddr == RA_CTRL) && reg_wdata[0] && !busy;
  assign tail_eff    = tail_wr ? wr_addr_val : tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= wr_addr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= reg_wdata[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tail_q <= '0;
    else if (tail_wr) tail_q <= wr_addr_val;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      RA_BASE:  reg_rdata = 32'(base_q);
      RA_COUNT: reg_rdata = 32'(count_q);
      RA_TAIL:  reg_rdata = 32'(tail_q);
      RA_CUR:   reg_rdata = 32'(cur_addr);
      RA_STAT:  reg_rdata = {30'd0, busy, suspended};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rdf_ring_ptr.sv
module rdf_ring_ptr
  import rdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [LEN_W-1:0]  count_q,
  input  logic [ADDR_W-1:0] tail_eff,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              at_tail
);
  logic [LEN_W-1:0] idx_q;
  logic [LEN_W-1:0] idx_d;
  logic [LEN_W-1:0] last_idx;
  logic             idx_en;

  assign last_idx = count_q - LEN_W'(1);
  assign idx_en   = start || adv;

  always_comb begin
    if (start)                  idx_d = '0;
    else if (idx_q >= last_idx) idx_d = '0;
    else                        idx_d = idx_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign cur_addr = base_q + (ADDR_W'(idx_q) << DESC_SHIFT);
  assign at_tail  = (cur_addr == tail_eff);
endmodule

// File: rtl/rdf_fetch_fsm.sv
module rdf_fetch_fsm
  import rdf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              at_tail,
  input  logic              tail_wr,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [DESC_W-1:0] desc_data,
  output logic [ADDR_W-1:0] desc_addr,
  output logic              adv,
  output logic              busy,
  output logic              suspended,
  output logic              suspend_pulse
);
  localparam logic [WCNT_W-1:0] WCNT_LAST = WCNT_W'(DESC_WORDS - 1);

  fetch_st_e         st_q, st_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic              wcnt_en;
  logic              pulse_d, pulse_q;
  logic [DESC_W-1:0] buf_q;

  always_comb begin
    st_d    = st_q;
    wcnt_d  = wcnt_q;
    wcnt_en = 1'b0;
    pulse_d = 1'b0;
    adv     = 1'b0;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_CHK;
      ST_CHK: begin
        if (at_tail) begin
          st_d    = ST_SUSP;
          pulse_d = 1'b1;
        end else begin
          st_d    = ST_REQ;
          wcnt_d  = '0;
          wcnt_en = 1'b1;
        end
      end
      ST_REQ: if (mem_gnt) st_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rvalid) begin
          if (wcnt_q == WCNT_LAST) begin
            st_d = ST_HOLD;
          end else begin
            st_d    = ST_REQ;
            wcnt_d  = wcnt_q + WCNT_W'(1);
            wcnt_en = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (desc_ready) begin
          adv  = 1'b1;
          st_d = ST_CHK;
        end
      end
      ST_SUSP: begin
        if (start)                  st_d = ST_CHK;
        else if (tail_wr && !at_tail) st_d = ST_CHK;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wcnt_q <= '0;
    else if (wcnt_en) wcnt_q <= wcnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    logic cap_en;
    assign cap_en = (st_q == ST_WAIT) && mem_rvalid && (wcnt_q == WCNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      buf_q[g*WORD_W +: WORD_W] <= '0;
      else if (cap_en) buf_q[g*WORD_W +: WORD_W] <= mem_rdata;
    end
  end

  assign mem_req       = (st_q == ST_REQ);
  assign mem_addr      = cur_addr + ADDR_W'({wcnt_q, 2'b00});
  assign desc_valid    = (st_q == ST_HOLD);
  assign desc_data     = buf_q;
  assign desc_addr     = cur_addr;
  assign busy          = (st_q == ST_CHK) || (st_q == ST_REQ) ||
                         (st_q == ST_WAIT) || (st_q == ST_HOLD);
  assign suspended     = (st_q == ST_SUSP);
  assign suspend_pulse = pulse_q;
endmodule

// File: rtl/ring_desc_fetch.sv
module ring_desc_fetch
  import rdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [2:0]        reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [127:0]      desc_data,
  output logic [ADDR_W-1:0] desc_addr,
  output logic              suspended,
  output logic              suspend_pulse
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  count_q;
  logic [ADDR_W-1:0] tail_eff;
  logic [ADDR_W-1:0] cur_addr;
  logic              tail_wr;
  logic              start_req;
  logic              at_tail;
  logic              adv;
  logic              busy;

  rdf_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rdf_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .suspended (suspended),
    .cur_addr  (cur_addr),
    .base_q    (base_q),
    .count_q   (count_q),
    .tail_eff  (tail_eff),
    .tail_wr   (tail_wr),
    .start_req (start_req)
  );

  rdf_ring_ptr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_ptr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start_req),
    .adv      (adv),
    .base_q   (base_q),
    .count_q  (count_q),
    .tail_eff (tail_eff),
    .cur_addr (cur_addr),
    .at_tail  (at_tail)
  );

  rdf_fetch_fsm #(.ADDR_W(ADDR_W)) i_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .start         (start_req),
    .at_tail       (at_tail),
    .tail_wr       (tail_wr),
    .cur_addr      (cur_addr),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_gnt       (mem_gnt),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .desc_valid    (desc_valid),
    .desc_ready    (desc_ready),
    .desc_data     (desc_data),
    .desc_addr     (desc_addr),
    .adv           (adv),
    .busy          (busy),
    .suspended     (suspended),
    .suspend_pulse (suspend_pulse)
  );
endmodule

// File: rtl/rdf_chk.sv
module rdf_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_gnt,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [127:0]      desc_data,
  input logic [ADDR_W-1:0] desc_addr,
  input logic              suspended,
  input logic              suspend_pulse
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  // R4
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt |=> !mem_req);

  // R3
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R5
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_data) && $stable(desc_addr));

  // R6
  pulse_in_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_pulse |-> suspended);

  // R6
  pulse_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> suspend_pulse);

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_pulse |=> !suspend_pulse);

  // R12
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !mem_req && !desc_valid);
endmodule

bind ring_desc_fetch rdf_chk #(.ADDR_W(ADDR_W)) i_rdf_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_gnt       (mem_gnt),
  .desc_valid    (desc_valid),
  .desc_ready    (desc_ready),
  .desc_data     (desc_data),
  .desc_addr     (desc_addr),
  .suspended     (suspended),
  .suspend_pulse (suspend_pulse)
);

// File: tb/test_ring_desc_fetch.sv
`timescale 1ns/1ps
module test_ring_desc_fetch;
  localparam int AW = 16;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_waddr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [2:0]    reg_raddr = '0;
  logic [31:0]   reg_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_gnt = 1'b0;
  logic          mem_rvalid = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          desc_valid;
  logic          desc_ready = 1'b0;
  logic [127:0]  desc_data;
  logic [AW-1:0] desc_addr;
  logic          suspended;
  logic          suspend_pulse;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int pulses = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  ring_desc_fetch #(.ADDR_W(AW), .LEN_W(LW)) i_ring_desc_fetch (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_data(desc_data), .desc_addr(desc_addr),
    .suspended(suspended), .suspend_pulse(suspend_pulse)
  );

  function automatic logic [31:0] memf(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  function automatic logic [127:0] desc_exp(input logic [AW-1:0] d);
    return {memf(d + 16'd12), memf(d + 16'd8), memf(d + 16'd4), memf(d)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: grant and response driven on falling edges
  bit            pend = 0;
  int            dly = 0;
  logic [AW-1:0] paddr = '0;
  bit            req_seen = 0;
  logic [AW-1:0] addr_seen = '0;
  always @(negedge clk) begin
    if (mem_gnt && req_seen) begin
      pend  = 1;
      paddr = addr_seen;
      dly   = cyc % 3;
    end
    mem_rvalid = 1'b0;
    if (pend) begin
      if (dly == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = memf(paddr);
        pend       = 0;
      end else begin
        dly--;
      end
    end
    mem_gnt   = mem_req && !pend && ((cyc % 3) != 2);
    req_seen  = mem_req;
    addr_seen = mem_addr;
  end

  always @(negedge clk) if (suspend_pulse) pulses++;

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr    = 1'b1;
    reg_waddr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  logic [AW-1:0] base_e;
  int            len_e;
  int            idx_e;

  task automatic run(input int n_exp, input bit disturb);
    int got = 0;
    int stage = 0;
    int guard = 0;
    int p0 = pulses;
    while (!suspended && guard < 3000) begin
      bit rdy = 0;
      if (desc_valid) begin
        rdy = ((cyc % 4) != 1);
        if (rdy) begin
          logic [AW-1:0] ea = base_e + AW'(idx_e * 16);
          string tag = (got > 0 && idx_e == 0) ? "R7 wrap descriptor" : "R3 descriptor data";
          chk(desc_data == desc_exp(ea), tag, desc_data, desc_exp(ea));
          chk(desc_addr == ea, "R3 descriptor address", desc_addr, ea);
          idx_e = (idx_e + 1) % len_e;
          got++;
        end
      end
      desc_ready = rdy;
      if (disturb && got >= 1 && stage < 3) begin
        reg_wr = 1'b1;
        case (stage)
          0: begin reg_waddr = 3'd1; reg_wdata = 32'h7770; end
          1: begin reg_waddr = 3'd2; reg_wdata = 32'd1; end
          default: begin reg_waddr = 3'd0; reg_wdata = 32'd1; end
        endcase
        stage++;
      end else begin
        reg_wr = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    desc_ready = 1'b0;
    reg_wr     = 1'b0;
    chk(guard < 3000, "R6 run reached suspension", guard, 3000);
    chk(got == n_exp, "R6 descriptors per burst", got, n_exp);
    chk(pulses - p0 == 1, "R6 one pulse on suspension", pulses - p0, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(!mem_req, "R1 mem_req after reset", mem_req, 0);
    chk(!desc_valid, "R1 desc_valid after reset", desc_valid, 0);
    chk(!suspended && !suspend_pulse, "R1 suspend outputs after reset", suspended, 0);
    rd(3'd5, r); chk(r == 0, "R1 status after reset", r, 0);
    rd(3'd4, r); chk(r == 0, "R1 current pointer after reset", r, 0);

    wr(3'd1, 32'h123F);
    rd(3'd1, r); chk(r == 32'h1230, "R11 base low bits dropped", r, 32'h1230);
    wr(3'd3, 32'h0107);
    rd(3'd3, r); chk(r == 32'h0100, "R11 tail low bits dropped", r, 32'h0100);

    for (int len = 1; len <= 7; len++) begin
      int p0;
      base_e = AW'(16'h1000 + len * 16'h200);
      len_e  = len;
      wr(3'd1, 32'(base_e));
      p0 = pulses;
      wr(3'd3, 32'(base_e));
      repeat (3) @(negedge clk);
      chk(pulses == p0, "R8 equal tail write no pulse", pulses - p0, 0);
      wr(3'd2, 32'(len));
      p0 = pulses;
      wr(3'd0, 32'd1);
      idx_e = 0;
      repeat (3) @(negedge clk);
      chk(suspended, "R2 start at tail suspends", suspended, 1);
      chk(pulses - p0 == 1, "R2 start at tail pulses once", pulses - p0, 1);
      rd(3'd4, r); chk(r == 32'(base_e), "R2 start loads current from base", r, base_e);

      for (int a = 1; a <= len; a++) begin
        int step = (a < len) ? a : (len - idx_e) % len;
        int t;
        if (step == 0) continue;
        t = (idx_e + step) % len;
        wr(3'd3, 32'(base_e + AW'(t * 16)));
        run(step, step == 2);
        rd(3'd4, r);
        chk(r == 32'(base_e + AW'(idx_e * 16)), "R10 current pointer readback", r,
            base_e + AW'(idx_e * 16));
        rd(3'd5, r); chk(r == 32'd1, "R6 status suspended", r, 1);
        if (step == 2) begin
          rd(3'd1, r); chk(r == 32'(base_e), "R9 base write ignored while busy", r, base_e);
          rd(3'd2, r); chk(r == 32'(len), "R9 count write ignored while busy", r, len);
        end
        p0 = pulses;
        wr(3'd3, 32'(base_e + AW'(idx_e * 16)));
        for (int k = 0; k < 4; k++) begin
          chk(suspended && !mem_req && !desc_valid, "R8 equal tail keeps suspension",
              {suspended, mem_req, desc_valid}, 3'b100);
          @(negedge clk);
        end
        chk(pulses == p0, "R8 no pulse on equal tail", pulses - p0, 0);
      end
      chk(idx_e == 0, "R7 ring back at base", idx_e, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule